// File: doc/BRIEF.md
# Broadcast Completion Retry Controller

This block runs the sending side of one broadcast activation. On a start request it issues a push command, then watches a 2-bit activation status returned by the broadcast fabric until the activation drains or is abandoned. A source-side timeout sends it straight back to another push. Destination-side timeouts are tallied, and only when the tally passes a fixed threshold does the controller request an examination of the destinations. If the examination finds that every destination has responded, the controller pushes again. Otherwise it counts the examination and, once the count reaches a programmable limit, it ends the attempt with a give-up result.

The result is reported as a one-cycle done pulse carrying a 2-bit code. Retries are never reported as a final result; they always loop back to a new push. Four running statistics are kept: source retries, destination retries, activations that completed only after a retry, and the total busy cycles spent on all finished activations.

Top module: `bcast_retry_ctrl`

## Requirements
- R1: During and directly after reset, push_o, exam_req_o, done_o and busy_o are low, result_o is 0, and all four statistics read 0.
- R2: start_i sampled high while the controller is idle gives a push_o pulse exactly one cycle later. busy_o is high from that push cycle through the done cycle. start_i has no effect while busy_o is high.
- R3: Status codes are 0 idle, 1 active, 2 destination timeout and 3 source timeout. Status 0 seen while waiting gives done_o in that same cycle with result_o = 3 (complete).
- R4: Status 3 seen while waiting adds one to src_retries_o and gives a new push_o in the next cycle.
- R5: Each status-2 cycle while waiting adds one to a destination-timeout tally. The cycle that takes the tally above DEST_TMO_LIMIT (default 20, so the 21st) raises exam_req_o in the next cycle and clears the tally. Twenty consecutive status-2 cycles followed by status 0 give no examination.
- R6: If unresp_i is 0 in an exam_req_o cycle, dst_retries_o increases by one and push_o follows in the next cycle.
- R7: If unresp_i is non-zero in an exam_req_o cycle, the examination count increases by one. When the count reaches retry_limit_i, done_o rises in that cycle with result_o = 2 (give up). Otherwise waiting resumes with a cleared tally.
- R8: Every push clears both the destination-timeout tally and the examination count.
- R9: A complete result reached after more than one push in the same activation adds one to retry_ok_o.
- R10: On every done pulse, elapsed_o increases by the number of cycles from the first push through the done cycle, inclusive.
- R11: done_o lasts one cycle per activation. result_o is 0 whenever done_o is low. Code 1 (retry) never appears on result_o.
- R12: Status 1 seen while waiting changes nothing; the controller keeps waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a new activation |
| status_i | input | 2 | Activation status from the fabric |
| unresp_i | input | UNRESP_W | Destinations still unresponsive, valid during exam_req_o |
| retry_limit_i | input | LIM_W | Examinations allowed before giving up |
| push_o | output | 1 | Push command, one cycle per attempt |
| exam_req_o | output | 1 | Request an examination of the destinations |
| busy_o | output | 1 | Activation in progress |
| done_o | output | 1 | Final result valid, one-cycle pulse |
| result_o | output | 2 | 3 complete, 2 give up, 0 when not done |
| src_retries_o | output | STAT_W | Source-timeout retries |
| dst_retries_o | output | STAT_W | Retries after a clean examination |
| retry_ok_o | output | STAT_W | Completions that needed a retry |
| elapsed_o | output | ACC_W | Accumulated busy cycles of finished activations |

## Verification
The hardest situation to reach is a give-up after several examinations. Each examination needs more than twenty uninterrupted destination-timeout cycles, and the examination count must survive the return to waiting while the tally restarts. The bench drives a status stream that defaults to destination timeout, with a fixed non-zero unresponsive count and a retry limit of three, so three complete timeout windows must pass before the give-up. A second hard case is a source timeout arriving in the middle of a timeout window. Only the clearing of the tally on the re-push prevents an examination there, so the bench places fifteen timeouts before the source timeout and twenty after it.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

   typedef enum logic [1:0] {
      ACT_IDLE   = 2'd0,
      ACT_BUSY   = 2'd1,
      ACT_DSTTMO = 2'd2,
      ACT_SRCTMO = 2'd3
   } act_status_e;

   localparam logic [1:0] RES_NONE   = 2'd0;
   localparam logic [1:0] RES_RETRY  = 2'd1;
   localparam logic [1:0] RES_GIVEUP = 2'd2;
   localparam logic [1:0] RES_DONE   = 2'd3;

   typedef enum logic [1:0] {
      S_IDLE,
      S_PUSH,
      S_WAIT,
      S_EXAM
   } ctl_state_e;

endpackage

// File: rtl/bcr_stat_ctr.sv
module bcr_stat_ctr #(
   parameter int W        = 16,
   parameter int IW       = 1,
   parameter bit SATURATE = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc_en,
   input  logic [IW-1:0] inc_val,
   output logic [W-1:0]  count_o
);

   if (IW > W) begin : g_bad_width
      $error("bcr_stat_ctr: increment wider than counter");
   end

   logic [W-1:0] inc_ext;
   logic [W-1:0] nxt;

   assign inc_ext = W'(inc_val);

   if (SATURATE) begin : g_sat
      logic [W:0] sum_w;
      assign sum_w = {1'b0, count_o} + {1'b0, inc_ext};
      assign nxt   = sum_w[W] ? {W{1'b1}} : sum_w[W-1:0];
   end else begin : g_wrap
      assign nxt = count_o + inc_ext;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      count_o <= '0;
      else if (inc_en) count_o <= nxt;
   end

endmodule

// File: rtl/bcr_fsm.sv
module bcr_fsm
   import bcr_pkg::*;
#(
   parameter int DEST_TMO_LIMIT = 20,
   parameter int LIM_W          = 8,
   parameter int CYC_W          = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [1:0]       status_i,
   input  logic             unresp_zero_i,
   input  logic [LIM_W-1:0] retry_limit_i,
   output logic             push_o,
   output logic             exam_o,
   output logic             busy_o,
   output logic             done_o,
   output logic [1:0]       result_o,
   output logic             src_evt_o,
   output logic             dst_evt_o,
   output logic             ok_evt_o,
   output logic [CYC_W-1:0] elapsed_o
);

   localparam int DT_W = $clog2(DEST_TMO_LIMIT + 1);

   if (DEST_TMO_LIMIT < 1) begin : g_bad_limit
      $error("bcr_fsm: DEST_TMO_LIMIT must be at least 1");
   end
   if (CYC_W < 2) begin : g_bad_cyc
      $error("bcr_fsm: CYC_W too small");
   end

   ctl_state_e       state_q, state_d;
   logic [DT_W-1:0]  dt_q;
   logic [LIM_W-1:0] ex_q;
   logic [CYC_W-1:0] cyc_q;
   logic             first_q;
   logic             retried_q;
   logic             dt_full;
   logic             exam_hit;
   act_status_e      st;

   assign st       = act_status_e'(status_i);
   assign dt_full  = (dt_q == DT_W'(DEST_TMO_LIMIT));
   assign exam_hit = ({1'b0, ex_q} + 1'b1) >= {1'b0, retry_limit_i};
   assign busy_o   = (state_q != S_IDLE);
   assign push_o   = (state_q == S_PUSH);
   assign exam_o   = (state_q == S_EXAM);
   assign elapsed_o = cyc_q + 1'b1;

   always_comb begin
      state_d   = state_q;
      done_o    = 1'b0;
      result_o  = RES_NONE;
      src_evt_o = 1'b0;
      dst_evt_o = 1'b0;
      ok_evt_o  = 1'b0;
      unique case (state_q)
         S_IDLE: if (start_i) state_d = S_PUSH;
         S_PUSH: state_d = S_WAIT;
         S_WAIT: begin
            unique case (st)
               ACT_IDLE: begin
                  done_o   = 1'b1;
                  result_o = RES_DONE;
                  ok_evt_o = retried_q;
                  state_d  = S_IDLE;
               end
               ACT_SRCTMO: begin
                  src_evt_o = 1'b1;
                  state_d   = S_PUSH;
               end
               ACT_DSTTMO: if (dt_full) state_d = S_EXAM;
               default: state_d = S_WAIT;
            endcase
         end
         S_EXAM: begin
            if (unresp_zero_i) begin
               dst_evt_o = 1'b1;
               state_d   = S_PUSH;
            end else if (exam_hit) begin
               done_o   = 1'b1;
               result_o = RES_GIVEUP;
               state_d  = S_IDLE;
            end else begin
               state_d = S_WAIT;
            end
         end
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= S_IDLE;
         dt_q      <= '0;
         ex_q      <= '0;
         cyc_q     <= '0;
         first_q   <= 1'b0;
         retried_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == S_IDLE) begin
            if (start_i) begin
               cyc_q     <= '0;
               first_q   <= 1'b1;
               retried_q <= 1'b0;
            end
         end else begin
            cyc_q <= cyc_q + 1'b1;
         end
         if (push_o) begin
            dt_q    <= '0;
            ex_q    <= '0;
            first_q <= 1'b0;
            if (!first_q) retried_q <= 1'b1;
         end else if (state_q == S_WAIT && st == ACT_DSTTMO) begin
            dt_q <= dt_full ? '0 : dt_q + 1'b1;
         end else if (exam_o && !unresp_zero_i) begin
            ex_q <= ex_q + 1'b1;
         end
      end
   end

   assert_push_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      push_o |=> !push_o);
   assert_start_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> push_o);
   assert_complete_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && result_o == RES_DONE) |-> (status_i == 2'd0));
   assert_src_repush_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_WAIT && status_i == 2'd3) |=> push_o);
   assert_exam_after_dtmo_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(exam_o) |-> ($past(status_i) == 2'd2));
   assert_giveup_in_exam_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && result_o == RES_GIVEUP) |-> (exam_o && !unresp_zero_i));
   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   assert_no_retry_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
      result_o != RES_RETRY);

endmodule

// File: rtl/bcast_retry_ctrl.sv
module bcast_retry_ctrl
   import bcr_pkg::*;
#(
   parameter int DEST_TMO_LIMIT = 20,
   parameter int LIM_W          = 8,
   parameter int UNRESP_W       = 8,
   parameter int STAT_W         = 16,
   parameter int CYC_W          = 24,
   parameter int ACC_W          = 40,
   parameter bit SATURATE       = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [1:0]          status_i,
   input  logic [UNRESP_W-1:0] unresp_i,
   input  logic [LIM_W-1:0]    retry_limit_i,
   output logic                push_o,
   output logic                exam_req_o,
   output logic                busy_o,
   output logic                done_o,
   output logic [1:0]          result_o,
   output logic [STAT_W-1:0]   src_retries_o,
   output logic [STAT_W-1:0]   dst_retries_o,
   output logic [STAT_W-1:0]   retry_ok_o,
   output logic [ACC_W-1:0]    elapsed_o
);

   if (ACC_W < CYC_W) begin : g_bad_acc
      $error("bcast_retry_ctrl: ACC_W must not be below CYC_W");
   end

   logic             src_evt, dst_evt, ok_evt;
   logic [CYC_W-1:0] op_cycles;

   bcr_fsm #(
      .DEST_TMO_LIMIT (DEST_TMO_LIMIT),
      .LIM_W          (LIM_W),
      .CYC_W          (CYC_W)
   ) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .status_i      (status_i),
      .unresp_zero_i (unresp_i == '0),
      .retry_limit_i (retry_limit_i),
      .push_o        (push_o),
      .exam_o        (exam_req_o),
      .busy_o        (busy_o),
      .done_o        (done_o),
      .result_o      (result_o),
      .src_evt_o     (src_evt),
      .dst_evt_o     (dst_evt),
      .ok_evt_o      (ok_evt),
      .elapsed_o     (op_cycles)
   );

   logic [2:0]             evt_vec;
   logic [2:0][STAT_W-1:0] cnt_vec;
   assign evt_vec = {ok_evt, dst_evt, src_evt};

   for (genvar k = 0; k < 3; k++) begin : g_evt_ctr
      bcr_stat_ctr #(.W(STAT_W), .IW(1), .SATURATE(SATURATE)) u_ctr (
         .clk     (clk),
         .rst_n   (rst_n),
         .inc_en  (evt_vec[k]),
         .inc_val (1'b1),
         .count_o (cnt_vec[k])
      );
   end

   assign src_retries_o = cnt_vec[0];
   assign dst_retries_o = cnt_vec[1];
   assign retry_ok_o    = cnt_vec[2];

   bcr_stat_ctr #(.W(ACC_W), .IW(CYC_W), .SATURATE(SATURATE)) u_elapsed (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_en  (done_o),
      .inc_val (op_cycles),
      .count_o (elapsed_o)
   );

   assert_ok_only_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (retry_ok_o != $past(retry_ok_o)) |-> $past(done_o && result_o == RES_DONE));
   assert_elapsed_on_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (elapsed_o != $past(elapsed_o)) |-> $past(done_o));

endmodule

// File: tb/test_bcast_retry_ctrl.sv
module test_bcast_retry_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [1:0]  status_i = 2'd1;
   logic [7:0]  unresp_i = 8'd0;
   logic [7:0]  retry_limit_i = 8'd1;
   logic        push_o, exam_req_o, busy_o, done_o;
   logic [1:0]  result_o;
   logic [15:0] src_retries_o, dst_retries_o, retry_ok_o;
   logic [39:0] elapsed_o;

   always #2.5 clk = ~clk;

   bcast_retry_ctrl i_bcast_retry_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .status_i(status_i),
      .unresp_i(unresp_i), .retry_limit_i(retry_limit_i),
      .push_o(push_o), .exam_req_o(exam_req_o), .busy_o(busy_o),
      .done_o(done_o), .result_o(result_o),
      .src_retries_o(src_retries_o), .dst_retries_o(dst_retries_o),
      .retry_ok_o(retry_ok_o), .elapsed_o(elapsed_o)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference: 0 idle, 1 push, 2 wait, 3 examine
   int     m_st = 0, m_dt = 0, m_ex = 0, m_cyc = 0, m_pushes = 0;
   longint m_src = 0, m_dst = 0, m_ok = 0, m_acc = 0;
   bit     done_seen;
   int     last_res, n_push, n_exam;

   always @(negedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_dt = 0; m_ex = 0; m_cyc = 0; m_pushes = 0;
         m_src = 0; m_dst = 0; m_ok = 0; m_acc = 0;
      end else begin
         int  nst;
         bit  e_done;
         int  e_res;
         nst = m_st; e_done = 0; e_res = 0;
         // registered statistics before this cycle's update
         chk(src_retries_o == m_src, "R4 src_retries", src_retries_o, m_src);
         chk(dst_retries_o == m_dst, "R6 dst_retries", dst_retries_o, m_dst);
         chk(retry_ok_o == m_ok, "R9 retry_ok", retry_ok_o, m_ok);
         chk(elapsed_o == m_acc, "R10 elapsed", elapsed_o, m_acc);
         if (m_st != 0) m_cyc++;
         case (m_st)
            0: if (start_i) begin nst = 1; m_cyc = 0; m_pushes = 0; end
            1: begin m_pushes++; m_dt = 0; m_ex = 0; nst = 2; end
            2: begin
               if (status_i == 2'd0) begin
                  e_done = 1; e_res = 3;
                  if (m_pushes > 1) m_ok++;
                  m_acc += m_cyc; nst = 0;
               end else if (status_i == 2'd3) begin
                  m_src++; nst = 1;
               end else if (status_i == 2'd2) begin
                  m_dt++;
                  if (m_dt > 20) begin m_dt = 0; nst = 3; end
               end
            end
            default: begin
               if (unresp_i == 0) begin
                  m_dst++; nst = 1;
               end else begin
                  m_ex++;
                  if (m_ex >= retry_limit_i) begin
                     e_done = 1; e_res = 2; m_acc += m_cyc; nst = 0;
                  end else nst = 2;
               end
            end
         endcase
         chk(push_o == (m_st == 1), "R2 push_o", push_o, m_st == 1);
         chk(exam_req_o == (m_st == 3), "R5 exam_req_o", exam_req_o, m_st == 3);
         chk(busy_o == (m_st != 0), "R2 busy_o", busy_o, m_st != 0);
         chk(done_o == e_done, "R11 done_o", done_o, e_done);
         chk(result_o == e_res, "R3 R7 result_o", result_o, e_res);
         m_st = nst;
      end
      if (done_o) begin done_seen = 1; last_res = result_o; end
      if (push_o) n_push++;
      if (exam_req_o) n_exam++;
   end

   int sq[$];
   int dflt = 0;
   int start_left = 0;
   int cyc_count = 0;

   task automatic tick();
      @(posedge clk); #1;
      cyc_count++;
      start_i = (start_left > 0);
      if (start_left > 0) start_left--;
      status_i = (sq.size() > 0) ? 2'(sq.pop_front()) : 2'(dflt);
   endtask

   task automatic run_op(input int hold, output int res, output longint el);
      longint acc0;
      acc0 = elapsed_o;
      done_seen = 0; n_push = 0; n_exam = 0;
      start_left = hold;
      tick();
      while (!done_seen) tick();
      sq.delete();
      dflt = 1;
      tick(); tick();
      res = last_res;
      el  = elapsed_o - acc0;
   endtask

   initial begin
      int     res;
      longint el, s0, d0, o0;
      repeat (3) @(posedge clk);
      #1;
      chk(push_o == 0 && busy_o == 0 && done_o == 0, "R1 outputs in reset", {push_o, busy_o, done_o}, 0);
      chk(result_o == 0, "R1 result in reset", result_o, 0);
      rst_n = 1'b1;
      tick();
      chk(src_retries_o == 0 && dst_retries_o == 0 && retry_ok_o == 0 && elapsed_o == 0,
          "R1 stats after reset", elapsed_o, 0);

      // plain completion with start held while busy (R2 ignore, R12 active wait)
      sq = '{1, 1, 1, 1, 0}; dflt = 0; o0 = retry_ok_o;
      run_op(3, res, el);
      chk(res == 3, "R3 complete code", res, 3);
      chk(n_push == 1, "R2 start ignored while busy", n_push, 1);
      chk(el == 4, "R10 elapsed of plain op", el, 4);
      chk(retry_ok_o == o0, "R9 no retry counted", retry_ok_o, o0);

      // source timeout then completion
      sq = '{1, 1, 3, 1, 0}; dflt = 0; s0 = src_retries_o; o0 = retry_ok_o;
      run_op(1, res, el);
      chk(n_push == 2, "R4 re-push count", n_push, 2);
      chk(src_retries_o == s0 + 1, "R4 source retry", src_retries_o, s0 + 1);
      chk(retry_ok_o == o0 + 1, "R9 success on retry", retry_ok_o, o0 + 1);
      chk(el == 4, "R10 elapsed with retry", el, 4);

      // exactly the threshold: no examination
      sq.delete(); sq.push_back(1); sq.push_back(1);
      for (int i = 0; i < 20; i++) sq.push_back(2);
      sq.push_back(0); dflt = 0;
      run_op(1, res, el);
      chk(n_exam == 0, "R5 twenty timeouts no exam", n_exam, 0);
      chk(res == 3, "R5 completes", res, 3);

      // one over the threshold, clean examination, retry
      sq.delete(); sq.push_back(1); sq.push_back(1);
      for (int i = 0; i < 21; i++) sq.push_back(2);
      sq.push_back(1); sq.push_back(1); sq.push_back(0); dflt = 0;
      d0 = dst_retries_o; unresp_i = 0;
      run_op(1, res, el);
      chk(n_exam == 1, "R5 exam after 21", n_exam, 1);
      chk(dst_retries_o == d0 + 1, "R6 destination retry", dst_retries_o, d0 + 1);
      chk(n_push == 2 && res == 3, "R6 re-push then complete", n_push, 2);
      chk(el == 25, "R10 elapsed with exam", el, 25);

      // source timeout mid-window clears the tally
      sq.delete(); sq.push_back(1); sq.push_back(1);
      for (int i = 0; i < 15; i++) sq.push_back(2);
      sq.push_back(3); sq.push_back(1);
      for (int i = 0; i < 20; i++) sq.push_back(2);
      sq.push_back(0); dflt = 0;
      run_op(1, res, el);
      chk(n_exam == 0, "R8 tally cleared by push", n_exam, 0);
      chk(res == 3, "R8 completes", res, 3);

      // give up at limit 1
      sq.delete(); dflt = 2; unresp_i = 8'd3; retry_limit_i = 8'd1;
      run_op(1, res, el);
      chk(res == 2, "R7 give-up code", res, 2);
      chk(n_exam == 1 && n_push == 1, "R7 single exam", n_exam, 1);
      chk(el == 23, "R10 elapsed give-up", el, 23);

      // give up at limit 3 after three windows
      sq.delete(); dflt = 2; unresp_i = 8'd2; retry_limit_i = 8'd3;
      run_op(1, res, el);
      chk(res == 2, "R7 give-up after limit", res, 2);
      chk(n_exam == 3, "R7 exam count", n_exam, 3);
      chk(el == 67, "R10 elapsed three windows", el, 67);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule